// File: doc/BRIEF.md
# Asynchronous Bus Slave Handshake

This block is the target side of a strobe-handshaked parallel bus transfer. No bus clock times it. A master first sets up an address, an address modifier, a direction line, a long-word line and, for writes, the data. It then pulls the address strobe and one or both data strobes low. The block brings the strobes into its own clock domain, checks that the address falls in its window, and works out the access width from the two data strobes, the long-word line and address bit 1. It then either completes the cycle on a small local register file or refuses it.

Completion is signalled by pulling the transfer-acknowledge output low. A refused cycle pulls the transfer-error output low instead. On reads the block drives the data bus and raises a drive-enable before it acknowledges. The chosen response stays asserted until the master lets both data strobes go high. The block then drops the response and stops driving the data bus. An address outside the window gets no response at all, so another target on the bus can claim it.

Top module: `async_bus_slave`

## Requirements
- R1: After reset, `xfer_ok_n` and `xfer_err_n` are high, `rdata_oe` is low, and every register reads back as zero.
- R2: If `bus_addr[15:4]` differs from the window base `0xA5C`, the block gives no response while the strobes stay low for 20 cycles, and no register changes.
- R3: For an address inside the window, an address modifier other than `0x29` or `0x2D` gives a transfer error.
- R4: With both data strobes low, `long_n` low and `bus_addr[1]` = 0, the access is 32-bit and uses lanes 0 to 3. Lane k is bits [8k+7:8k] of the register and of the data bus. `bus_addr[3:2]` picks the register.
- R5: With both data strobes low and `long_n` high, the access is 16-bit. It uses lanes 0 and 1 when `bus_addr[1]` = 0 and lanes 2 and 3 when it is 1.
- R6: With `long_n` high and only one data strobe low, the access is 8-bit. `dstrb1_n` alone selects lane 2*A1. `dstrb0_n` alone selects lane 2*A1+1, where A1 is `bus_addr[1]`.
- R7: Any other strobe combination gives a transfer error: `long_n` low with a single data strobe, or `long_n` low with `bus_addr[1]` = 1.
- R8: Register 3 accepts only 32-bit accesses. A narrower access to it gives a transfer error.
- R9: On an acknowledged read, `rdata_oe` rises at least one cycle before `xfer_ok_n` falls and stays high while it is low. Lanes outside the access read as zero on `rdata_out`. `rdata_oe` stays low on writes, on errors and after release.
- R10: `xfer_ok_n` and `xfer_err_n` stay low until both data strobes are high. They are released within 4 cycles after that.
- R11: A transfer that ends in an error, or that gets no response, changes no register.
- R12: `xfer_ok_n` and `xfer_err_n` are never low at the same time.
- R13: Strobes pass through a two-stage synchroniser, so no response appears before the third clock cycle after the strobes fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to sample the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Address from the master |
| bus_am | input | 6 | Address modifier code |
| addr_strb_n | input | 1 | Address strobe, active low |
| dstrb0_n | input | 1 | Data strobe 0, active low |
| dstrb1_n | input | 1 | Data strobe 1, active low |
| long_n | input | 1 | Long-word select, active low |
| wr_dir_n | input | 1 | Direction: low for write, high for read |
| wdata_in | input | 32 | Write data from the master |
| rdata_out | output | 32 | Read data, valid while `rdata_oe` is high |
| rdata_oe | output | 1 | Drive enable for the data bus |
| xfer_ok_n | output | 1 | Transfer acknowledge, active low |
| xfer_err_n | output | 1 | Transfer error, active low |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, a window base of 0xA5C0, four registers, modifier codes 0x29 and 0x2D, register 3 restricted to word access, and two synchroniser stages. With only four registers and a 16-byte window, random addresses reach every register, every lane and both halves many times. The word-only register and the out-of-window range are reached often too, so width errors, modifier errors and silent misses are all hit alongside correct accesses. The two-stage synchroniser fixes the response latency at a handful of cycles, which puts the early-response bound and the release deadline inside short, fixed polling windows.

// File: rtl/abs_pkg.sv
package abs_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;
  localparam int AM_W   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RDRIVE,
    ST_ACK,
    ST_ERR,
    ST_QUIET
  } xfer_state_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      m[8*k +: 8] = {8{lanes[k]}};
    end
    return m;
  endfunction
endpackage

// File: rtl/abs_sync.sv
module abs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= RST_VAL;
      end
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/abs_access_decode.sv
module abs_access_decode #(
  parameter int                     ADDR_W    = 16,
  parameter int                     NUM_REGS  = 4,
  parameter int                     IDX_W     = 2,
  parameter logic [ADDR_W-1:0]      BASE_ADDR = 16'hA5C0,
  parameter logic [abs_pkg::AM_W-1:0] AM_A    = 6'h29,
  parameter logic [abs_pkg::AM_W-1:0] AM_B    = 6'h2D,
  parameter logic [NUM_REGS-1:0]    WORD_ONLY = '0
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [abs_pkg::AM_W-1:0]  am,
  input  logic                      ds0_act,
  input  logic                      ds1_act,
  input  logic                      long_act,
  output logic                      hit,
  output logic                      accept,
  output logic [abs_pkg::LANES-1:0] lanes,
  output logic [IDX_W-1:0]          idx
);
  localparam int WIN_LSB = IDX_W + 2;

  logic legal;
  logic am_ok;
  logic word_ok;
  logic a1;

  assign a1  = addr[1];
  assign idx = addr[WIN_LSB-1:2];

  always_comb begin
    hit = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]) &&
          ({1'b0, idx} < NUM_REGS[IDX_W:0]);
  end

  // width decode: strobes, long-word line and address bit 1
  always_comb begin
    legal = 1'b0;
    lanes = '0;
    unique case ({ds1_act, ds0_act, long_act})
      3'b111: begin
        legal = !a1;
        lanes = a1 ? 4'b0000 : 4'b1111;
      end
      3'b110: begin
        legal = 1'b1;
        lanes = a1 ? 4'b1100 : 4'b0011;
      end
      3'b100: begin
        legal = 1'b1;
        lanes = a1 ? 4'b0100 : 4'b0001;
      end
      3'b010: begin
        legal = 1'b1;
        lanes = a1 ? 4'b1000 : 4'b0010;
      end
      default: begin
        legal = 1'b0;
        lanes = '0;
      end
    endcase
  end

  always_comb begin
    am_ok   = (am == AM_A) || (am == AM_B);
    word_ok = !WORD_ONLY[idx] || (lanes == 4'b1111);
    accept  = am_ok && legal && word_ok;
  end
endmodule

// File: rtl/abs_reg_bank.sv
module abs_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [abs_pkg::LANES-1:0]  lanes,
  input  logic [abs_pkg::DATA_W-1:0] wdata,
  output logic [abs_pkg::DATA_W-1:0] rdata
);
  logic [abs_pkg::DATA_W-1:0] words [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < abs_pkg::LANES; b++) begin : g_lane
      logic       byte_en;
      logic [7:0] byte_q;

      assign byte_en = wr_en && lanes[b] && (idx == r[IDX_W-1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= '0;
        end else if (byte_en) begin
          byte_q <= wdata[8*b +: 8];
        end
      end

      assign words[r][8*b +: 8] = byte_q;
    end
  end

  assign rdata = words[idx];
endmodule

// File: rtl/async_bus_slave.sv
module async_bus_slave #(
  parameter int                       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]        BASE_ADDR   = 16'hA5C0,
  parameter int                       NUM_REGS    = 4,
  parameter logic [abs_pkg::AM_W-1:0] AM_A        = 6'h29,
  parameter logic [abs_pkg::AM_W-1:0] AM_B        = 6'h2D,
  parameter logic [NUM_REGS-1:0]      WORD_ONLY   = 4'b1000,
  parameter int                       SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [abs_pkg::AM_W-1:0]   bus_am,
  input  logic                       addr_strb_n,
  input  logic                       dstrb0_n,
  input  logic                       dstrb1_n,
  input  logic                       long_n,
  input  logic                       wr_dir_n,
  input  logic [abs_pkg::DATA_W-1:0] wdata_in,
  output logic [abs_pkg::DATA_W-1:0] rdata_out,
  output logic                       rdata_oe,
  output logic                       xfer_ok_n,
  output logic                       xfer_err_n
);
  import abs_pkg::*;

  localparam int IDX_W = $clog2(NUM_REGS);

  logic             rst_sync_n;
  logic [2:0]       strb_sync;
  logic             as_s;
  logic             ds0_s;
  logic             ds1_s;

  logic             hit;
  logic             accept;
  logic [LANES-1:0] lanes;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rd_word;

  xfer_state_t      state_q;
  xfer_state_t      state_nx;
  logic             wr_en;
  logic             load_rd;
  logic             ok_q;
  logic             err_q;
  logic             oe_q;
  logic             oe_nx;
  logic [DATA_W-1:0] rdata_q;

  // reset: asserted at once, released on a clock edge
  abs_sync #(
    .WIDTH  (1),
    .STAGES (2),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(1'b1),
    .d_sync (rst_sync_n)
  );

  abs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b111)
  ) u_strb_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .d_async({addr_strb_n, dstrb1_n, dstrb0_n}),
    .d_sync (strb_sync)
  );

  assign as_s  = strb_sync[2];
  assign ds1_s = strb_sync[1];
  assign ds0_s = strb_sync[0];

  abs_access_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .BASE_ADDR(BASE_ADDR),
    .AM_A     (AM_A),
    .AM_B     (AM_B),
    .WORD_ONLY(WORD_ONLY)
  ) u_decode (
    .addr    (bus_addr),
    .am      (bus_am),
    .ds0_act (!ds0_s),
    .ds1_act (!ds1_s),
    .long_act(!long_n),
    .hit     (hit),
    .accept  (accept),
    .lanes   (lanes),
    .idx     (idx)
  );

  abs_reg_bank #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr_en(wr_en),
    .idx  (idx),
    .lanes(lanes),
    .wdata(wdata_in),
    .rdata(rd_word)
  );

  // next-state logic
  always_comb begin
    state_nx = state_q;
    wr_en    = 1'b0;
    load_rd  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!as_s && (!ds0_s || !ds1_s)) begin
          state_nx = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (as_s || (ds0_s && ds1_s)) begin
          state_nx = ST_IDLE;
        end else if (!hit) begin
          state_nx = ST_QUIET;
        end else if (!accept) begin
          state_nx = ST_ERR;
        end else if (!wr_dir_n) begin
          wr_en    = 1'b1;
          state_nx = ST_ACK;
        end else begin
          load_rd  = 1'b1;
          state_nx = ST_RDRIVE;
        end
      end
      ST_RDRIVE: begin
        state_nx = ST_ACK;
      end
      ST_ACK, ST_ERR, ST_QUIET: begin
        if (ds0_s && ds1_s) begin
          state_nx = ST_IDLE;
        end
      end
      default: begin
        state_nx = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    oe_nx = (state_nx == ST_RDRIVE) || ((state_nx == ST_ACK) && oe_q);
  end

  // state and output registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_nx;
      ok_q    <= (state_nx == ST_ACK);
      err_q   <= (state_nx == ST_ERR);
      oe_q    <= oe_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (load_rd) begin
      rdata_q <= rd_word & lane_mask(lanes);
    end
  end

  assign xfer_ok_n  = !ok_q;
  assign xfer_err_n = !err_q;
  assign rdata_oe   = oe_q;
  assign rdata_out  = oe_q ? rdata_q : '0;
endmodule

// File: rtl/abs_checker.sv
module abs_checker (
  input logic clk,
  input logic rst_n,
  input logic addr_strb_n,
  input logic dstrb0_n,
  input logic dstrb1_n,
  input logic wr_dir_n,
  input logic xfer_ok_n,
  input logic xfer_err_n,
  input logic rdata_oe
);
  assert_resp_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xfer_ok_n && !xfer_err_n));

  assert_ok_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ok_n && (!dstrb0_n || !dstrb1_n)) |=> !xfer_ok_n);

  assert_err_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_err_n && (!dstrb0_n || !dstrb1_n)) |=> !xfer_err_n);

  assert_drive_before_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xfer_ok_n) && rdata_oe) |-> $past(rdata_oe));

  assert_drive_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (wr_dir_n && xfer_err_n));

  assert_resp_needs_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xfer_ok_n) || $fell(xfer_err_n)) |-> !addr_strb_n);
endmodule

bind async_bus_slave abs_checker u_abs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_strb_n(addr_strb_n),
  .dstrb0_n   (dstrb0_n),
  .dstrb1_n   (dstrb1_n),
  .wr_dir_n   (wr_dir_n),
  .xfer_ok_n  (xfer_ok_n),
  .xfer_err_n (xfer_err_n),
  .rdata_oe   (rdata_oe)
);

// File: tb/tb_async_bus_slave.sv
`timescale 1ns/1ps
module tb_async_bus_slave;
  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [5:0]  bus_am;
  logic        addr_strb_n;
  logic        dstrb0_n;
  logic        dstrb1_n;
  logic        long_n;
  logic        wr_dir_n;
  logic [31:0] wdata_in;
  logic [31:0] rdata_out;
  logic        rdata_oe;
  logic        xfer_ok_n;
  logic        xfer_err_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] model [4];

  localparam logic [11:0] WIN = 12'hA5C;

  async_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_am(bus_am),
    .addr_strb_n(addr_strb_n), .dstrb0_n(dstrb0_n), .dstrb1_n(dstrb1_n),
    .long_n(long_n), .wr_dir_n(wr_dir_n), .wdata_in(wdata_in),
    .rdata_out(rdata_out), .rdata_oe(rdata_oe),
    .xfer_ok_n(xfer_ok_n), .xfer_err_n(xfer_err_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected width decode: {legal, lanes}; s0/s1/lw = 1 means active
  function automatic logic [4:0] exp_dec(input bit s0, input bit s1, input bit lw, input bit a1);
    if (s0 && s1 && lw)   return a1 ? 5'b0_0000 : 5'b1_1111;
    if (s0 && s1 && !lw)  return a1 ? 5'b1_1100 : 5'b1_0011;
    if (!s0 && s1 && !lw) return a1 ? 5'b1_0100 : 5'b1_0001;
    if (s0 && !s1 && !lw) return a1 ? 5'b1_1000 : 5'b1_0010;
    return 5'b0_0000;
  endfunction

  function automatic logic [31:0] mask_of(input logic [3:0] l);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{l[k]}};
    return m;
  endfunction

  task automatic xfer(input logic [15:0] a, input logic [5:0] am, input bit s0, input bit s1,
                      input bit lw, input bit wr, input logic [31:0] wd,
                      output int resp, output logic [31:0] rd, output bit oe_seen);
    int n;
    @(negedge clk);
    bus_addr = a; bus_am = am; long_n = !lw; wr_dir_n = !wr; wdata_in = wd;
    @(negedge clk);
    addr_strb_n = 1'b0; dstrb0_n = !s0; dstrb1_n = !s1;
    resp = 0; rd = '0; oe_seen = 0; n = 0;
    while (n < 20 && resp == 0) begin
      @(negedge clk);
      n++;
      chk(xfer_ok_n || xfer_err_n, "R12", {30'd0, xfer_ok_n, xfer_err_n}, 32'd3);
      if (!xfer_ok_n) resp = 1;
      else if (!xfer_err_n) resp = 2;
    end
    if (resp != 0) chk(n >= 3, "R13", n, 3);
    rd = rdata_out;
    oe_seen = rdata_oe;
    // response held while strobes stay low
    @(negedge clk);
    if (resp == 1) chk(!xfer_ok_n, "R10", xfer_ok_n, 0);
    if (resp == 2) chk(!xfer_err_n, "R10", xfer_err_n, 0);
    addr_strb_n = 1'b1; dstrb0_n = 1'b1; dstrb1_n = 1'b1;
    if (resp != 0) begin
      @(negedge clk);
      if (resp == 1) chk(!xfer_ok_n, "R10", xfer_ok_n, 0);
      else chk(!xfer_err_n, "R10", xfer_err_n, 0);
      n = 0;
      while (n < 3 && (!xfer_ok_n || !xfer_err_n)) begin
        @(negedge clk);
        n++;
      end
      chk(xfer_ok_n && xfer_err_n, "R10", {30'd0, xfer_ok_n, xfer_err_n}, 32'd3);
    end
    @(negedge clk);
    chk(!rdata_oe, "R9", rdata_oe, 0);
  endtask

  task automatic run(input logic [15:0] a, input logic [5:0] am, input bit s0, input bit s1,
                     input bit lw, input bit wr, input logic [31:0] wd);
    int resp; int eresp;
    logic [31:0] rd;
    bit oe_seen;
    logic [4:0] dec;
    logic [1:0] idx;
    string tag;
    dec = exp_dec(s0, s1, lw, a[1]);
    idx = a[3:2];
    if (a[15:4] != WIN) begin eresp = 0; tag = "R2"; end
    else if (am != 6'h29 && am != 6'h2D) begin eresp = 2; tag = "R3"; end
    else if (!dec[4]) begin eresp = 2; tag = "R7"; end
    else if (idx == 2'd3 && dec[3:0] != 4'hF) begin eresp = 2; tag = "R8"; end
    else begin
      eresp = 1;
      if (dec[3:0] == 4'hF) tag = "R4";
      else if ($countones(dec[3:0]) == 2) tag = "R5";
      else tag = "R6";
    end
    xfer(a, am, s0, s1, lw, wr, wd, resp, rd, oe_seen);
    chk(resp == eresp, tag, resp, eresp);
    if (eresp == 1 && wr) begin
      model[idx] = (model[idx] & ~mask_of(dec[3:0])) | (wd & mask_of(dec[3:0]));
      chk(!oe_seen, "R9", oe_seen, 0);
    end else if (eresp == 1) begin
      chk(oe_seen, "R9", oe_seen, 1);
      chk(rd == (model[idx] & mask_of(dec[3:0])), tag, rd, model[idx] & mask_of(dec[3:0]));
    end else begin
      chk(!oe_seen, "R9", oe_seen, 0);
    end
  endtask

  task automatic read_word(input logic [1:0] idx, input string req);
    int resp; logic [31:0] rd; bit oe_seen;
    xfer({WIN, idx, 2'b00}, 6'h29, 1, 1, 1, 0, 32'd0, resp, rd, oe_seen);
    chk(resp == 1, req, resp, 1);
    chk(rd == model[idx], req, rd, model[idx]);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (R10) actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_addr = '0; bus_am = '0; addr_strb_n = 1'b1;
    dstrb0_n = 1'b1; dstrb1_n = 1'b1; long_n = 1'b1; wr_dir_n = 1'b1; wdata_in = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(xfer_ok_n && xfer_err_n, "R1", {30'd0, xfer_ok_n, xfer_err_n}, 3);
    chk(!rdata_oe, "R1", rdata_oe, 0);
    for (int i = 0; i < 4; i++) read_word(i[1:0], "R1");

    // R4 word write and read
    run({WIN, 4'b0000}, 6'h29, 1, 1, 1, 1, 32'hDEAD_BEEF);
    run({WIN, 4'b0000}, 6'h2D, 1, 1, 1, 0, 32'h0);
    // R5 both halves
    run({WIN, 4'b0100}, 6'h29, 1, 1, 0, 1, 32'h1234_5678);
    run({WIN, 4'b0110}, 6'h29, 1, 1, 0, 1, 32'hABCD_0000);
    run({WIN, 4'b0110}, 6'h29, 1, 1, 0, 0, 32'h0);
    read_word(2'd1, "R5");
    // R6 each lane
    run({WIN, 4'b1000}, 6'h29, 0, 1, 0, 1, 32'h0000_0011);
    run({WIN, 4'b1000}, 6'h29, 1, 0, 0, 1, 32'h0000_2200);
    run({WIN, 4'b1010}, 6'h29, 0, 1, 0, 1, 32'h0033_0000);
    run({WIN, 4'b1010}, 6'h29, 1, 0, 0, 1, 32'h4400_0000);
    run({WIN, 4'b1010}, 6'h29, 0, 1, 0, 0, 32'h0);
    read_word(2'd2, "R6");
    // R7 illegal combinations, R11 no effect
    run({WIN, 4'b0010}, 6'h29, 1, 1, 1, 1, 32'hFFFF_FFFF);
    run({WIN, 4'b0000}, 6'h29, 1, 0, 1, 1, 32'hFFFF_FFFF);
    read_word(2'd0, "R11");
    // R8 word-only register
    run({WIN, 4'b1100}, 6'h29, 1, 1, 1, 1, 32'hCAFE_F00D);
    run({WIN, 4'b1100}, 6'h29, 1, 1, 0, 1, 32'h5555_5555);
    run({WIN, 4'b1100}, 6'h29, 1, 0, 0, 0, 32'h0);
    read_word(2'd3, "R11");
    // R3 bad modifier, R2 outside window
    run({WIN, 4'b0100}, 6'h3D, 1, 1, 1, 1, 32'h9999_9999);
    run(16'h1230, 6'h29, 1, 1, 1, 1, 32'h7777_7777);
    run({WIN + 12'd1, 4'b0000}, 6'h29, 1, 1, 1, 1, 32'h7777_7777);
    read_word(2'd1, "R11");
    read_word(2'd0, "R2");

    // constrained random
    for (int t = 0; t < 220; t++) begin
      logic [15:0] a; logic [5:0] am; bit s0, s1, lw, wr;
      a  = ($urandom % 100 < 88) ? {WIN, 4'($urandom)} : 16'($urandom);
      am = ($urandom % 100 < 88) ? (($urandom % 2) ? 6'h29 : 6'h2D) : 6'($urandom);
      do begin
        s0 = 1'($urandom); s1 = 1'($urandom);
      end while (!s0 && !s1);
      lw = 1'($urandom);
      wr = 1'($urandom);
      run(a, am, s0, s1, lw, wr, $urandom);
    end
    for (int i = 0; i < 4; i++) read_word(i[1:0], "R11");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule